// File: doc/BRIEF.md
# Static Branch Speculation Controller

This block sits beside the fetch and issue stages of a small in-order dual-issue pipeline and handles a single unresolved conditional branch. It drives the fetch address. Every cycle that has no redirect, the address steps forward by one fetch group. When fetch hands over a decoded branch, the block chooses the next address from the branch alone. Unconditional branches are folded away at once. So are conditional branches whose condition is already known. Neither kind uses an execution slot.

A conditional branch whose condition is still being computed gets a static guess from its displacement sign, and a hint bit in the encoding can invert that guess. The block then enters a speculative state. While in that state, every instruction issued comes back marked speculative one cycle later, and marked write-backs are held. Any further branch is refused while the state lasts.

The condition logic eventually reports the real outcome. If the guess was right, the held write-backs are released and fetch carries on. If the guess was wrong, the block raises a one-cycle flush and moves fetch to the other path on the cycle after the report.

Top module: `brspec_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `fetch_pc` equals `RESET_PC`, and `flush`, `fold`, `spec_tag` and `br_stall` are all zero.
- R2: In a cycle that causes no redirect, `fetch_pc` advances by NSLOT*INSN_BYTES on the next cycle, wrapping modulo 2^AW.
- R3: An accepted branch with `br_uncond`=1 sets `fetch_pc` to `br_pc`+`br_disp` on the next cycle, pulses `fold` on that cycle, and does not start speculation.
- R4: An accepted conditional branch with `br_settled`=1 is folded. `fold` pulses on the next cycle, and `fetch_pc` moves to `br_pc`+`br_disp` if `br_settled_taken`=1 and otherwise takes its normal step. No speculation starts.
- R5: An accepted conditional branch with `br_settled`=0 is predicted taken exactly when `br_disp[AW-1]` XOR `br_hint` is 1. A taken prediction moves `fetch_pc` to `br_pc`+`br_disp` on the next cycle, and a not-taken prediction lets fetch step normally. `fold` stays 0 and speculation begins on the next cycle.
- R6: While speculation is active, any `br_valid` raises `br_stall` in the same cycle. The stalled branch does not change `fetch_pc` or the block's state.
- R7: Each `spec_tag[i]` equals, one cycle later, `iss_valid[i]` ANDed with speculation being active in the issue cycle.
- R8: `wb_en[i]` is `wb_valid[i]` in the same cycle, forced to 0 when `wb_spec[i]`=1 while speculation is active or `flush` is high.
- R9: A `res_valid` during speculation whose `res_taken` matches the prediction ends speculation on the next cycle. It causes no flush and no redirect.
- R10: A `res_valid` during speculation whose `res_taken` contradicts the prediction makes `flush` high for exactly the next cycle. On that cycle `fetch_pc` is `br_pc`+INSN_BYTES if the branch was predicted taken, or `br_pc`+`br_disp` if it was predicted not-taken. Speculation ends.
- R11: A `res_valid` while no speculation is active has no effect: no flush, and fetch keeps stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Decoded branch present this cycle |
| br_pc | input | AW | Address of the branch |
| br_disp | input | AW | Two's-complement displacement |
| br_uncond | input | 1 | Branch is unconditional |
| br_settled | input | 1 | Condition already known |
| br_settled_taken | input | 1 | Known condition value (taken) |
| br_hint | input | 1 | Inverts the static guess |
| br_stall | output | 1 | Branch refused, hold it in decode |
| res_valid | input | 1 | Condition logic reports outcome |
| res_taken | input | 1 | Reported outcome is taken |
| iss_valid | input | NSLOT | Instructions issued this cycle, per slot |
| spec_tag | output | NSLOT | Speculative mark for last cycle's issue |
| wb_valid | input | NSLOT | Write-back request per slot |
| wb_spec | input | NSLOT | Request belongs to a speculative instruction |
| wb_en | output | NSLOT | Write-back permitted |
| fetch_pc | output | AW | Next fetch address |
| fold | output | 1 | Branch folded last cycle |
| flush | output | 1 | Kill all speculative instructions |

## Verification
Most state faults in this block appear at the ports within one cycle. If the stored prediction or alternate target is wrong, the fetch address is wrong on the cycle after a contradicting outcome, and `flush` fires or stays quiet when it should not. If the speculative flag is stuck or lost, the fault shows the next cycle in the tags, the same cycle in `br_stall` and `wb_en`, or as a missing flush. The bench therefore compares every output on every cycle against a reference model, rather than checking only at the end of each scenario.

// File: rtl/brspec_pkg.sv
package brspec_pkg;

  typedef enum logic [1:0] {
    BK_NONE  = 2'd0,
    BK_FOLD  = 2'd1,
    BK_SPEC  = 2'd2,
    BK_STALL = 2'd3
  } br_kind_e;

  // Static guess: negative displacement means taken, hint flips it.
  function automatic logic static_guess(input logic disp_sign, input logic hint);
    return disp_sign ^ hint;
  endfunction

endpackage

// File: rtl/brspec_decode.sv
module brspec_decode
  import brspec_pkg::*;
#(
  parameter int AW         = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic          br_valid,
  input  logic [AW-1:0] br_pc,
  input  logic [AW-1:0] br_disp,
  input  logic          br_uncond,
  input  logic          br_settled,
  input  logic          br_settled_taken,
  input  logic          br_hint,
  input  logic          pending,
  output br_kind_e      kind,
  output logic          redirect,
  output logic [AW-1:0] redir_pc,
  output logic          pred_taken,
  output logic [AW-1:0] alt_pc
);

  localparam logic [AW-1:0] INSN_STEP = AW'(INSN_BYTES);

  logic [AW-1:0] tgt_pc;
  logic [AW-1:0] seq_pc;

  assign tgt_pc   = br_pc + br_disp;
  assign seq_pc   = br_pc + INSN_STEP;
  assign redir_pc = tgt_pc;

  always_comb begin
    kind       = BK_NONE;
    redirect   = 1'b0;
    pred_taken = 1'b0;
    alt_pc     = seq_pc;
    if (br_valid) begin
      if (pending) begin
        kind = BK_STALL;
      end else if (br_uncond) begin
        kind     = BK_FOLD;
        redirect = 1'b1;
      end else if (br_settled) begin
        kind     = BK_FOLD;
        redirect = br_settled_taken;
      end else begin
        kind       = BK_SPEC;
        pred_taken = static_guess(br_disp[AW-1], br_hint);
        redirect   = pred_taken;
        alt_pc     = pred_taken ? seq_pc : tgt_pc;
      end
    end
  end

endmodule

// File: rtl/brspec_track.sv
module brspec_track
  import brspec_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  br_kind_e      kind,
  input  logic          pred_taken,
  input  logic [AW-1:0] alt_pc,
  input  logic          res_valid,
  input  logic          res_taken,
  output logic          pending,
  output logic          flush,
  output logic          mispredict,
  output logic [AW-1:0] fix_pc
);

  logic resolve_now;
  logic pred_q;

  assign resolve_now = pending & res_valid;
  assign mispredict  = resolve_now & (res_taken != pred_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      pred_q  <= 1'b0;
      fix_pc  <= '0;
      flush   <= 1'b0;
    end else begin
      flush <= mispredict;
      if (resolve_now) begin
        pending <= 1'b0;
      end else if (kind == BK_SPEC) begin
        pending <= 1'b1;
        pred_q  <= pred_taken;
        fix_pc  <= alt_pc;
      end
    end
  end

endmodule

// File: rtl/brspec_fetch.sv
module brspec_fetch
  import brspec_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            NSLOT      = 2,
  parameter int            INSN_BYTES = 4,
  parameter logic [AW-1:0] RESET_PC   = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  br_kind_e      kind,
  input  logic          redirect,
  input  logic [AW-1:0] redir_pc,
  input  logic          mispredict,
  input  logic [AW-1:0] fix_pc,
  output logic [AW-1:0] fetch_pc,
  output logic          fold
);

  localparam logic [AW-1:0] GROUP_STEP = AW'(NSLOT * INSN_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc <= RESET_PC;
      fold     <= 1'b0;
    end else begin
      fold <= (kind == BK_FOLD);
      if (mispredict)    fetch_pc <= fix_pc;
      else if (redirect) fetch_pc <= redir_pc;
      else               fetch_pc <= fetch_pc + GROUP_STEP;
    end
  end

endmodule

// File: rtl/brspec_slots.sv
module brspec_slots #(
  parameter int NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pending,
  input  logic             flush,
  input  logic [NSLOT-1:0] iss_valid,
  input  logic [NSLOT-1:0] wb_valid,
  input  logic [NSLOT-1:0] wb_spec,
  output logic [NSLOT-1:0] spec_tag,
  output logic [NSLOT-1:0] wb_en
);

  logic block_spec;
  assign block_spec = pending | flush;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) spec_tag[s] <= 1'b0;
      else     spec_tag[s] <= iss_valid[s] & pending;
    end
    assign wb_en[s] = wb_valid[s] & ~(wb_spec[s] & block_spec);
  end

endmodule

// File: rtl/brspec_ctrl.sv
module brspec_ctrl
  import brspec_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            NSLOT      = 2,
  parameter int            INSN_BYTES = 4,
  parameter logic [AW-1:0] RESET_PC   = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_valid,
  input  logic [AW-1:0]    br_pc,
  input  logic [AW-1:0]    br_disp,
  input  logic             br_uncond,
  input  logic             br_settled,
  input  logic             br_settled_taken,
  input  logic             br_hint,
  output logic             br_stall,
  input  logic             res_valid,
  input  logic             res_taken,
  input  logic [NSLOT-1:0] iss_valid,
  output logic [NSLOT-1:0] spec_tag,
  input  logic [NSLOT-1:0] wb_valid,
  input  logic [NSLOT-1:0] wb_spec,
  output logic [NSLOT-1:0] wb_en,
  output logic [AW-1:0]    fetch_pc,
  output logic             fold,
  output logic             flush
);

  br_kind_e      kind;
  logic          redirect;
  logic [AW-1:0] redir_pc;
  logic          pred_taken;
  logic [AW-1:0] alt_pc;
  logic          pending;
  logic          mispredict;
  logic [AW-1:0] fix_pc;

  assign br_stall = (kind == BK_STALL);

  brspec_decode #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_decode (
    .br_valid(br_valid), .br_pc(br_pc), .br_disp(br_disp),
    .br_uncond(br_uncond), .br_settled(br_settled),
    .br_settled_taken(br_settled_taken), .br_hint(br_hint),
    .pending(pending), .kind(kind), .redirect(redirect),
    .redir_pc(redir_pc), .pred_taken(pred_taken), .alt_pc(alt_pc)
  );

  brspec_track #(.AW(AW)) u_track (
    .clk(clk), .rst(rst), .kind(kind), .pred_taken(pred_taken),
    .alt_pc(alt_pc), .res_valid(res_valid), .res_taken(res_taken),
    .pending(pending), .flush(flush), .mispredict(mispredict),
    .fix_pc(fix_pc)
  );

  brspec_fetch #(.AW(AW), .NSLOT(NSLOT), .INSN_BYTES(INSN_BYTES),
                 .RESET_PC(RESET_PC)) u_fetch (
    .clk(clk), .rst(rst), .kind(kind), .redirect(redirect),
    .redir_pc(redir_pc), .mispredict(mispredict), .fix_pc(fix_pc),
    .fetch_pc(fetch_pc), .fold(fold)
  );

  brspec_slots #(.NSLOT(NSLOT)) u_slots (
    .clk(clk), .rst(rst), .pending(pending), .flush(flush),
    .iss_valid(iss_valid), .wb_valid(wb_valid), .wb_spec(wb_spec),
    .spec_tag(spec_tag), .wb_en(wb_en)
  );

endmodule

// File: rtl/brspec_ctrl_chk.sv
module brspec_ctrl_chk #(
  parameter int AW         = 32,
  parameter int NSLOT      = 2,
  parameter int INSN_BYTES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             br_valid,
  input logic             br_stall,
  input logic             res_valid,
  input logic [NSLOT-1:0] iss_valid,
  input logic [NSLOT-1:0] spec_tag,
  input logic [NSLOT-1:0] wb_valid,
  input logic [NSLOT-1:0] wb_spec,
  input logic [NSLOT-1:0] wb_en,
  input logic [AW-1:0]    fetch_pc,
  input logic             flush
);

  localparam logic [AW-1:0] STEP = AW'(NSLOT * INSN_BYTES);

  // R2: quiet cycle gives a plain step
  a_r2_plain_step: assert property (@(posedge clk) disable iff (rst)
    (!br_valid && !res_valid) |=> (fetch_pc == $past(fetch_pc) + STEP));

  // R6: stall only for a presented branch, and it leaves fetch alone
  a_r6_stall_needs_branch: assert property (@(posedge clk) disable iff (rst)
    br_stall |-> br_valid);
  a_r6_stall_no_redirect: assert property (@(posedge clk) disable iff (rst)
    (br_stall && !res_valid) |=> (fetch_pc == $past(fetch_pc) + STEP));

  // R7: a tag only on a slot that issued
  a_r7_tag_from_issue: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((spec_tag & ~$past(iss_valid)) == '0));

  // R8: no enable without request, no speculative write during flush
  a_r8_wb_needs_req: assert property (@(posedge clk) disable iff (rst)
    (wb_en & ~wb_valid) == '0);
  a_r8_flush_blocks_spec: assert property (@(posedge clk) disable iff (rst)
    flush |-> ((wb_en & wb_spec) == '0));

  // R10: flush is a single pulse following an outcome report
  a_r10_flush_pulse: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);
  a_r10_flush_after_res: assert property (@(posedge clk) disable iff (rst)
    flush |-> $past(res_valid));

endmodule

bind brspec_ctrl brspec_ctrl_chk #(.AW(AW), .NSLOT(NSLOT), .INSN_BYTES(INSN_BYTES)) u_chk (
  .clk(clk), .rst(rst), .br_valid(br_valid), .br_stall(br_stall),
  .res_valid(res_valid), .iss_valid(iss_valid), .spec_tag(spec_tag),
  .wb_valid(wb_valid), .wb_spec(wb_spec), .wb_en(wb_en),
  .fetch_pc(fetch_pc), .flush(flush)
);

// File: tb/brspec_ctrl_bench.sv
module brspec_ctrl_bench;

  localparam int          AW    = 32;
  localparam int          NSLOT = 2;
  localparam int          IB    = 4;
  localparam logic [31:0] RPC   = 32'h0000_1000;
  localparam logic [31:0] GSTEP = NSLOT * IB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic             br_valid, br_uncond, br_settled, br_settled_taken, br_hint;
  logic [AW-1:0]    br_pc, br_disp;
  logic             br_stall, res_valid, res_taken, fold, flush;
  logic [NSLOT-1:0] iss_valid, spec_tag, wb_valid, wb_spec, wb_en;
  logic [AW-1:0]    fetch_pc;

  brspec_ctrl #(.AW(AW), .NSLOT(NSLOT), .INSN_BYTES(IB), .RESET_PC(RPC)) u_brspec_ctrl (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_pc(br_pc), .br_disp(br_disp),
    .br_uncond(br_uncond), .br_settled(br_settled),
    .br_settled_taken(br_settled_taken), .br_hint(br_hint), .br_stall(br_stall),
    .res_valid(res_valid), .res_taken(res_taken), .iss_valid(iss_valid),
    .spec_tag(spec_tag), .wb_valid(wb_valid), .wb_spec(wb_spec), .wb_en(wb_en),
    .fetch_pc(fetch_pc), .fold(fold), .flush(flush)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  logic        m_pend, m_pred, m_flush, m_fold;
  logic [31:0] m_pc, m_alt;
  logic [1:0]  m_tag;
  string       pc_why;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic guess(input logic [31:0] d, input logic h);
    return d[31] ^ h;
  endfunction

  task automatic idle();
    br_valid = 0; br_pc = '0; br_disp = '0; br_uncond = 0; br_settled = 0;
    br_settled_taken = 0; br_hint = 0; res_valid = 0; res_taken = 0;
    iss_valid = '0; wb_valid = '0; wb_spec = '0;
  endtask

  // one clock: check same-cycle outputs, advance model, check registered outputs
  task automatic cyc();
    logic [1:0]  exp_wb;
    logic        blk, acc, mis;
    logic [31:0] tgt;
    #1;
    chk("R6 br_stall", br_stall, br_valid & m_pend);
    blk    = m_pend | m_flush;
    exp_wb = wb_valid & ~(wb_spec & {NSLOT{blk}});
    chk("R8 wb_en", wb_en, exp_wb);
    @(posedge clk);
    acc = br_valid & ~m_pend;
    tgt = br_pc + br_disp;
    mis = m_pend & res_valid & (res_taken != m_pred);
    m_tag  = iss_valid & {NSLOT{m_pend}};
    m_fold = acc & (br_uncond | br_settled);
    m_flush = mis;
    pc_why = res_valid & ~m_pend ? "R11 fetch_pc" : "R2 fetch_pc";
    if (mis) begin
      m_pc = m_alt; pc_why = "R10 fetch_pc";
    end else if (acc && br_uncond) begin
      m_pc = tgt; pc_why = "R3 fetch_pc";
    end else if (acc && br_settled) begin
      m_pc = br_settled_taken ? tgt : m_pc + GSTEP; pc_why = "R4 fetch_pc";
    end else if (acc) begin
      m_pc = guess(br_disp, br_hint) ? tgt : m_pc + GSTEP; pc_why = "R5 fetch_pc";
    end else begin
      m_pc = m_pc + GSTEP;
      if (m_pend && res_valid) pc_why = "R9 fetch_pc";
    end
    if (m_pend && res_valid) m_pend = 0;
    else if (acc && !br_uncond && !br_settled) begin
      m_pend = 1;
      m_pred = guess(br_disp, br_hint);
      m_alt  = m_pred ? br_pc + IB : tgt;
    end
    @(negedge clk);
    chk(pc_why, fetch_pc, m_pc);
    chk(m_flush ? "R10 flush" : "R9 flush", flush, m_flush);
    chk("R7 spec_tag", spec_tag, m_tag);
    chk("R4 fold", fold, m_fold);
  endtask

  task automatic branch(input logic [31:0] pc, input logic [31:0] d,
                        input logic u, input logic s, input logic st, input logic h);
    br_valid = 1; br_pc = pc; br_disp = d; br_uncond = u;
    br_settled = s; br_settled_taken = st; br_hint = h;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    idle();
    m_pend = 0; m_pred = 0; m_flush = 0; m_fold = 0; m_tag = '0;
    m_pc = RPC; m_alt = '0;
    repeat (3) @(negedge clk);
    chk("R1 fetch_pc", fetch_pc, RPC);
    chk("R1 flush", flush, 0);
    chk("R1 spec_tag", spec_tag, 0);
    chk("R1 fold", fold, 0);
    chk("R1 br_stall", br_stall, 0);
    rst = 0;
    cyc();                                       // R2 plain stepping
    cyc();
    // R3 unconditional fold
    branch(32'h2000, 32'h40, 1, 0, 0, 0); cyc(); idle();
    // R4 settled taken, then settled not-taken
    branch(32'h3000, 32'hFFFF_FFF0, 0, 1, 1, 0); cyc(); idle();
    branch(32'h3100, 32'h20, 0, 1, 0, 0); cyc(); idle();
    // R5 backward -> predicted taken; R6 second branch stalls; R7 tags; R10 wrong
    branch(32'h4000, 32'hFFFF_FF00, 0, 0, 0, 0); cyc(); idle();
    iss_valid = 2'b11; wb_valid = 2'b11; wb_spec = 2'b10; cyc(); idle();
    branch(32'h5000, 32'h8, 1, 0, 0, 0); cyc(); idle();
    res_valid = 1; res_taken = 0; iss_valid = 2'b01; cyc(); idle();
    wb_valid = 2'b11; wb_spec = 2'b11; cyc(); idle();   // R8 during flush
    // R5 forward with hint -> predicted taken; R9 correct outcome
    branch(32'h6000, 32'h100, 0, 0, 0, 1); cyc(); idle();
    res_valid = 1; res_taken = 1; cyc(); idle();
    // R5 forward no hint -> not taken; R10 wrong to target
    branch(32'h7000, 32'h80, 0, 0, 0, 0); cyc(); idle();
    res_valid = 1; res_taken = 1; cyc(); idle();
    // R11 stray outcome
    res_valid = 1; res_taken = 1; cyc(); idle();
    // R2 wrap
    branch(32'hFFFF_FFF0, 32'h8, 1, 0, 0, 0); cyc(); idle();
    cyc();
    // random mix
    for (int n = 0; n < 3000; n++) begin
      idle();
      if ($urandom_range(0, 9) < 4) begin
        branch($urandom & 32'hFFFF_FFFC,
               32'($signed($urandom_range(0, 63)) - 32) << 2,
               $urandom_range(0, 4) == 0, $urandom_range(0, 3) == 0,
               1'($urandom), $urandom_range(0, 5) == 0);
      end
      res_valid = $urandom_range(0, 3) == 0;
      res_taken = 1'($urandom);
      iss_valid = 2'($urandom);
      wb_valid  = 2'($urandom);
      wb_spec   = 2'($urandom);
      cyc();
    end
    idle();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule